// File: doc/BRIEF.md
# Latched Bidirectional Parity Transceiver

This block joins two byte-wide buses, side A and side B, each of which carries one parity bit alongside its eight data bits. A word moves in one direction at a time. The side that receives the word drives it out through an output-enable, and the word passes through the hold latch of the side it came from. When that latch is open, the source word reaches the far side in the same cycle. When the latch is closed, the far side keeps seeing the word captured at the last clock edge on which the latch was open.

The parity bit driven onto the destination bus can take one of two forms. In feed-through mode it is the source word's own parity bit. In generate mode it is computed afresh from the eight data bits. An odd/even select sets the parity convention. Each side has its own hold latch, and each latch feeds an active-low error flag. The source-side flag checks the word as received. The destination-side latch captures the word actually being driven, so its flag checks the driven word, including a parity bit the block generated itself.

The pads are modelled as separate input, output and drive-enable ports. The latch holding registers are clocked, and their contents are cleared by an asynchronous active-low reset whose release is synchronised inside the block.

Top module: `xcvr_par_top`

## Requirements
- R1: With oe_b high and le_a high, b_data_o equals a_data_i in the same cycle.
- R2: With oe_a high and le_b high, a_data_o equals b_data_i in the same cycle.
- R3: With sel_gen low (feed-through), the driven parity bit equals the source word's parity bit, in both directions.
- R4: With sel_gen high (generate), the driven parity bit makes the count of ones over the nine driven bits odd when odd_sel is 1 and even when odd_sel is 0, in both directions.
- R5: While a side's latch enable is low, the word forwarded from that side is the one present at the last rising clock edge on which the enable was high, and changes on that side's inputs have no effect on it.
- R6: err_a_n (or err_b_n) is 0 exactly when the count of ones over the nine bits held in the A (or B) latch disagrees with the convention set by odd_sel, where odd_sel 1 means odd and 0 means even.
- R7: The destination latch captures the word being driven. In generate mode with the destination latch open, the destination flag stays 1 even when the source parity is wrong. In feed-through mode the destination flag follows the source word's parity.
- R8: a_drive_o follows oe_a and b_drive_o follows oe_b.
- R9: After reset, both holding registers are zero. With both latch enables low, the forwarded data and parity are 0, and with odd_sel at 0 both flags read 1.
- R10: The flags are combinational. A change of odd_sel, or a latch opening, shows on them without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the latch holding registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_a | input | 1 | Drive side A (B-to-A transfer) |
| oe_b | input | 1 | Drive side B (A-to-B transfer) |
| le_a | input | 1 | Side-A latch open when high |
| le_b | input | 1 | Side-B latch open when high |
| sel_gen | input | 1 | 1: generate the driven parity, 0: feed it through |
| odd_sel | input | 1 | 1: odd parity convention, 0: even |
| a_data_i | input | 8 | Side-A data pins, received |
| a_par_i | input | 1 | Side-A parity pin, received |
| a_data_o | output | 8 | Side-A data pins, driven |
| a_par_o | output | 1 | Side-A parity pin, driven |
| a_drive_o | output | 1 | Side-A pad drive enable |
| b_data_i | input | 8 | Side-B data pins, received |
| b_par_i | input | 1 | Side-B parity pin, received |
| b_data_o | output | 8 | Side-B data pins, driven |
| b_par_o | output | 1 | Side-B parity pin, driven |
| b_drive_o | output | 1 | Side-B pad drive enable |
| err_a_n | output | 1 | Side-A parity error, active low |
| err_b_n | output | 1 | Side-B parity error, active low |

## Verification
The assertions assume that oe_a and oe_b are never high together. If both were high, each side's latch would capture a word derived from the other side and the transfer direction would be undefined. The directed tasks turn one enable off before turning the other on. The properties that compare the source pins with the destination pins also assume that, while its enable is high, the receiving side's input pins carry the value the pads would feed back. The bench therefore drives the undriven side's inputs independently and judges the destination flag only through the looped-back driven word.

// File: rtl/xcvr_par_pkg.sv
package xcvr_par_pkg;
  localparam int unsigned DATA_W_DEF = 8;

  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } par_conv_e;

  typedef enum logic {
    PAR_FEED = 1'b0,
    PAR_GEN  = 1'b1
  } par_src_e;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xcvr_hold_latch.sv
module xcvr_hold_latch #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] held_o,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (le) hold_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign held_o = hold_q;
  assign q_o    = le ? d : hold_q;
endmodule

// File: rtl/xcvr_parity.sv
module xcvr_parity
  import xcvr_par_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  input  par_conv_e         conv,
  output logic              gen_o,
  output logic              ok_o
);
  localparam int unsigned NODES = 2 * DATA_W - 1;
  logic [NODES-1:0] tree;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_leaf
      assign tree[NODES-1-gi] = data[gi];
    end
    for (gi = DATA_W - 2; gi >= 0; gi--) begin : g_node
      assign tree[gi] = tree[2*gi+1] ^ tree[2*gi+2];
    end
  endgenerate

  assign gen_o = tree[0] ^ (conv == PAR_ODD);
  assign ok_o  = (gen_o == par);
endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_par_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_par,
  input  par_src_e          mode,
  input  par_conv_e         conv,
  output logic [DATA_W-1:0] out_data,
  output logic              out_par
);
  logic gen_par;
  logic gen_ok;

  xcvr_parity #(.DATA_W(DATA_W)) gen_i (
    .data (src_data),
    .par  (src_par),
    .conv (conv),
    .gen_o(gen_par),
    .ok_o (gen_ok)
  );

  always_comb begin
    out_data = src_data;
    out_par  = (mode == PAR_GEN) ? gen_par : src_par;
  end
endmodule

// File: rtl/xcvr_par_top.sv
module xcvr_par_top
  import xcvr_par_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe_a,
  input  logic              oe_b,
  input  logic              le_a,
  input  logic              le_b,
  input  logic              sel_gen,
  input  logic              odd_sel,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              a_par_i,
  output logic [DATA_W-1:0] a_data_o,
  output logic              a_par_o,
  output logic              a_drive_o,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic              b_par_i,
  output logic [DATA_W-1:0] b_data_o,
  output logic              b_par_o,
  output logic              b_drive_o,
  output logic              err_a_n,
  output logic              err_b_n
);
  localparam int unsigned WORD_W = DATA_W + 1;

  logic      rst_sync_n;
  par_src_e  mode;
  par_conv_e conv;

  logic [WORD_W-1:0] a_pin_w, b_pin_w;
  logic [WORD_W-1:0] a_held, b_held;
  logic [WORD_W-1:0] a_q, b_q;
  logic [WORD_W-1:0] a_lat_d, b_lat_d;
  logic [WORD_W-1:0] a_view, b_view;
  logic [DATA_W-1:0] to_a_data, to_b_data;
  logic              to_a_par, to_b_par;
  logic              a_gen_unused, b_gen_unused;
  logic              a_ok, b_ok;

  assign mode = sel_gen ? PAR_GEN : PAR_FEED;
  assign conv = odd_sel ? PAR_ODD : PAR_EVEN;

  xcvr_rst_sync #(.STAGES(2)) rst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // Word layout: parity in the top bit, data below.
  always_comb begin
    a_pin_w = {a_par_i, a_data_i};
    b_pin_w = {b_par_i, b_data_i};
    // Source view taken from the received pins and the holding register,
    // so the forward path never passes through the opposite capture mux.
    a_view  = le_a ? a_pin_w : a_held;
    b_view  = le_b ? b_pin_w : b_held;
    // Destination latch sees the pad value: the driven word when driving.
    a_lat_d = oe_a ? {to_a_par, to_a_data} : a_pin_w;
    b_lat_d = oe_b ? {to_b_par, to_b_data} : b_pin_w;
  end

  xcvr_hold_latch #(.W(WORD_W)) lat_a_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .le    (le_a),
    .d     (a_lat_d),
    .held_o(a_held),
    .q_o   (a_q)
  );

  xcvr_hold_latch #(.W(WORD_W)) lat_b_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .le    (le_b),
    .d     (b_lat_d),
    .held_o(b_held),
    .q_o   (b_q)
  );

  xcvr_route #(.DATA_W(DATA_W)) route_ab_i (
    .src_data(a_view[DATA_W-1:0]),
    .src_par (a_view[DATA_W]),
    .mode    (mode),
    .conv    (conv),
    .out_data(to_b_data),
    .out_par (to_b_par)
  );

  xcvr_route #(.DATA_W(DATA_W)) route_ba_i (
    .src_data(b_view[DATA_W-1:0]),
    .src_par (b_view[DATA_W]),
    .mode    (mode),
    .conv    (conv),
    .out_data(to_a_data),
    .out_par (to_a_par)
  );

  xcvr_parity #(.DATA_W(DATA_W)) chk_a_i (
    .data (a_q[DATA_W-1:0]),
    .par  (a_q[DATA_W]),
    .conv (conv),
    .gen_o(a_gen_unused),
    .ok_o (a_ok)
  );

  xcvr_parity #(.DATA_W(DATA_W)) chk_b_i (
    .data (b_q[DATA_W-1:0]),
    .par  (b_q[DATA_W]),
    .conv (conv),
    .gen_o(b_gen_unused),
    .ok_o (b_ok)
  );

  assign a_data_o  = to_a_data;
  assign a_par_o   = to_a_par;
  assign b_data_o  = to_b_data;
  assign b_par_o   = to_b_par;
  assign a_drive_o = oe_a;
  assign b_drive_o = oe_b;
  assign err_a_n   = a_ok;
  assign err_b_n   = b_ok;
endmodule

// File: rtl/xcvr_par_chk.sv
module xcvr_par_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe_a,
  input logic              oe_b,
  input logic              le_a,
  input logic              le_b,
  input logic              sel_gen,
  input logic              odd_sel,
  input logic [DATA_W-1:0] a_data_i,
  input logic              a_par_i,
  input logic [DATA_W-1:0] a_data_o,
  input logic              a_par_o,
  input logic              a_drive_o,
  input logic [DATA_W-1:0] b_data_i,
  input logic              b_par_i,
  input logic [DATA_W-1:0] b_data_o,
  input logic              b_par_o,
  input logic              b_drive_o,
  input logic              err_a_n,
  input logic              err_b_n
);
  a_r1_pass_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_b && le_a) |-> (b_data_o == a_data_i));

  a_r2_pass_ba: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a && le_b) |-> (a_data_o == b_data_i));

  a_r3_feed_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_b && le_a && !sel_gen) |-> (b_par_o == a_par_i));

  a_r4_gen_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_b && sel_gen) |-> ((^{b_par_o, b_data_o}) == odd_sel));

  a_r4_gen_ba: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a && sel_gen) |-> ((^{a_par_o, a_data_o}) == odd_sel));

  a_r5_hold_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_a && $past(!le_a) && $stable(sel_gen) && $stable(odd_sel))
      |-> ($stable(b_data_o) && $stable(b_par_o)));

  a_r6_src_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_b && le_a) |-> (err_a_n == ((^{a_par_i, a_data_i}) == odd_sel)));

  a_r7_dst_gen_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_b && le_b && sel_gen) |-> err_b_n);

  a_r8_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_drive_o && b_drive_o));
endmodule

bind xcvr_par_top xcvr_par_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .oe_a     (oe_a),
  .oe_b     (oe_b),
  .le_a     (le_a),
  .le_b     (le_b),
  .sel_gen  (sel_gen),
  .odd_sel  (odd_sel),
  .a_data_i (a_data_i),
  .a_par_i  (a_par_i),
  .a_data_o (a_data_o),
  .a_par_o  (a_par_o),
  .a_drive_o(a_drive_o),
  .b_data_i (b_data_i),
  .b_par_i  (b_par_i),
  .b_data_o (b_data_o),
  .b_par_o  (b_par_o),
  .b_drive_o(b_drive_o),
  .err_a_n  (err_a_n),
  .err_b_n  (err_b_n)
);

// File: tb/xcvr_par_top_tb_top.sv
`timescale 1ns/1ps
module xcvr_par_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       oe_a, oe_b, le_a, le_b, sel_gen, odd_sel;
  logic [7:0] a_data_i, b_data_i, a_data_o, b_data_o;
  logic       a_par_i, b_par_i, a_par_o, b_par_o;
  logic       a_drive_o, b_drive_o, err_a_n, err_b_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  xcvr_par_top dut_i (
    .clk(clk), .rst_n(rst_n), .oe_a(oe_a), .oe_b(oe_b), .le_a(le_a), .le_b(le_b),
    .sel_gen(sel_gen), .odd_sel(odd_sel),
    .a_data_i(a_data_i), .a_par_i(a_par_i), .a_data_o(a_data_o), .a_par_o(a_par_o),
    .a_drive_o(a_drive_o),
    .b_data_i(b_data_i), .b_par_i(b_par_i), .b_data_o(b_data_o), .b_par_o(b_par_o),
    .b_drive_o(b_drive_o), .err_a_n(err_a_n), .err_b_n(err_b_n)
  );

  function automatic logic gen_par(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  function automatic logic flag_ok(input logic [7:0] d, input logic p, input logic odd);
    return ((^{p, d}) == odd);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic settle;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; oe_a = 0; oe_b = 1; le_a = 0; le_b = 0;
    sel_gen = 0; odd_sel = 0;
    a_data_i = 8'h5C; a_par_i = 1; b_data_i = 8'h33; b_par_i = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk_eq("R9 b_data_o after reset", b_data_o, 0);
    chk_eq("R9 b_par_o after reset", b_par_o, 0);
    chk_eq("R9 err_a_n after reset", err_a_n, 1);
    chk_eq("R8 b_drive_o", b_drive_o, 1);
    chk_eq("R8 a_drive_o", a_drive_o, 0);
    odd_sel = 1; #1;
    chk_eq("R10 err_a_n on odd_sel change", err_a_n, 0);
    odd_sel = 0;
  endtask

  task automatic t_ab_feed;
    settle();
    oe_a = 0; oe_b = 1; le_a = 1; le_b = 1; sel_gen = 0; odd_sel = 0;
    a_data_i = 8'hA5; a_par_i = 1; #1;
    chk_eq("R1 b_data_o", b_data_o, 8'hA5);
    chk_eq("R3 b_par_o feed", b_par_o, 1);
    chk_eq("R6 err_a_n bad even", err_a_n, flag_ok(8'hA5, 1, 0));
    chk_eq("R7 err_b_n feed bad", err_b_n, 0);
    a_par_i = 0; #1;
    chk_eq("R6 err_a_n good even", err_a_n, 1);
    chk_eq("R7 err_b_n feed good", err_b_n, 1);
  endtask

  task automatic t_ab_gen;
    settle();
    oe_b = 1; le_a = 1; le_b = 1; sel_gen = 1;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] d;
      d = 8'h17 * (k + 3);
      odd_sel = k[0];
      a_data_i = d; a_par_i = ~gen_par(d, k[0]); #1;
      chk_eq("R4 b_par_o gen", b_par_o, gen_par(d, k[0]));
      chk_eq("R7 err_b_n gen ok", err_b_n, 1);
      chk_eq("R6 err_a_n src bad", err_a_n, 0);
    end
  endtask

  task automatic t_ba;
    settle();
    oe_b = 0; settle();
    oe_a = 1; le_a = 1; le_b = 1; sel_gen = 0; odd_sel = 1;
    b_data_i = 8'h3C; b_par_i = 1; #1;
    chk_eq("R2 a_data_o", a_data_o, 8'h3C);
    chk_eq("R3 a_par_o feed", a_par_o, 1);
    chk_eq("R6 err_b_n odd good", err_b_n, flag_ok(8'h3C, 1, 1));
    sel_gen = 1; b_par_i = 0; #1;
    chk_eq("R4 a_par_o gen", a_par_o, gen_par(8'h3C, 1));
    chk_eq("R7 err_a_n gen ok", err_a_n, 1);
    chk_eq("R6 err_b_n odd bad", err_b_n, 0);
    settle();
    oe_a = 0; settle();
    oe_b = 1;
  endtask

  task automatic t_hold;
    settle();
    oe_b = 1; sel_gen = 0; odd_sel = 0; le_a = 1; le_b = 1;
    a_data_i = 8'hC3; a_par_i = 0;
    @(posedge clk); @(negedge clk);
    le_a = 0; le_b = 0;
    a_data_i = 8'h81; a_par_i = 1; #1;
    chk_eq("R5 b_data_o held", b_data_o, 8'hC3);
    chk_eq("R5 b_par_o held", b_par_o, 0);
    chk_eq("R6 err_a_n on held word", err_a_n, 1);
    repeat (2) @(negedge clk);
    a_data_i = 8'hFF; #1;
    chk_eq("R5 b_data_o still held", b_data_o, 8'hC3);
    chk_eq("R7 err_b_n held dest", err_b_n, 1);
    odd_sel = 1; #1;
    chk_eq("R10 err_b_n follows odd_sel", err_b_n, 0);
    odd_sel = 0;
    le_a = 1; #1;
    chk_eq("R10 err_a_n on latch open", err_a_n, flag_ok(8'hFF, 1, 0));
  endtask

  initial begin
    t_reset();
    t_ab_feed();
    t_ab_gen();
    t_ba();
    t_hold();
    settle();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule